// File: doc/BRIEF.md
# Fractional Pixel Clock Divider

This block produces the pixel clock rate for the graphics and display path. It divides a fast source by a ratio taken from a 7-bit code. The code is piecewise:

- low codes step the ratio in quarters;
- middle codes step it in halves;
- high codes step it in whole cycles.

The ratio runs from 1 up to 64. The block does not gate or switch clocks. It stays on one fabric clock and advances a phase accumulator only on cycles where the selected source tick is high. Two tick inputs stand for the two possible source branches, and a select bit picks one of them.

Each time the accumulator wraps, the block issues a one-cycle enable strobe. Downstream logic uses the strobe as a clock enable. The block also drives a registered output that toggles on every strobe, giving a roughly square clock at half the strobe rate. The average strobe rate equals the programmed ratio exactly. For fractional ratios, the spacing between strobes alternates between the neighbouring whole cycle counts.

A new code takes effect only at a strobe. Software can therefore rewrite the code at any time without producing a runt period.

Top module: `gfx_frac_clkdiv`

## Requirements
- R1: For codes 0 to 63, the division ratio is 1 + code/4 selected-source ticks per strobe. Internally this is N = code + 4 in quarter-tick units.
- R2: For codes 64 to 94, the ratio is 17 + (code − 64)/2, so N = 68 + 2·(code − 64).
- R3: For codes 95 to 127, the ratio is code − 63 (so code 127 gives 64), and N = 4·(code − 63).
- R4: Once a code is in force, any run of N consecutive selected ticks produces exactly 4 strobes.
- R5: The gap between two strobes, in ticks, is always either floor(N/4) or ceil(N/4). For whole-number ratios, every gap equals the ratio.
- R6: A change on `ratio_code` is captured only in a cycle that issues a strobe. The strobe that follows still uses the old ratio, and the new ratio applies from then on.
- R7: `strobe_o` lasts one cycle per event. `clk_o` inverts in exactly the cycles where `strobe_o` is high and holds its value in all other cycles.
- R8: While `rst` is high, `strobe_o` and `clk_o` are 0 and the ratio is 1 (N = 4). With code 0 held and ticks present, a strobe then appears in every cycle after reset is released.
- R9: When `src_sel` = 0 the accumulator advances on `tick_a`; when `src_sel` = 1 it advances on `tick_b`. In either case the unselected tick has no effect, and no strobe follows a cycle without a selected tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; everything is synchronous to it |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 1 | Selects the tick source: 0 = `tick_a`, 1 = `tick_b` |
| tick_a | input | 1 | Tick qualifier for source option A |
| tick_b | input | 1 | Tick qualifier for source option B |
| ratio_code | input | 7 | Piecewise division ratio code |
| strobe_o | output | 1 | One-cycle enable strobe at the divided rate |
| clk_o | output | 1 | Registered output that toggles on each strobe |

## Verification
The bench builds the block with its default parameters: a 7-bit code, a 9-bit quarter-unit ratio and a step of 4. At these widths all 128 codes can be applied in a single run. Each code is held for a window of exactly N ticks, in which the strobe count, every gap and the toggle count are checked. The run therefore covers every boundary between the quarter, half and whole regions, including the largest ratio of 64. It also covers a slow-to-fast code change and source selection driven by a tick that arrives only every other cycle.

// File: rtl/gfxdiv_pkg.sv
package gfxdiv_pkg;

  // Region boundaries of the piecewise ratio code
  localparam int HALF_FIRST  = 64;
  localparam int WHOLE_FIRST = 95;

  // Quarter-unit ratio offsets for each region
  localparam int QTR_BASE    = 4;   // ratio 1.00
  localparam int HALF_BASE   = 68;  // ratio 17.00
  localparam int WHOLE_SHIFT = 63;

endpackage

// File: rtl/gfxdiv_ratio_dec.sv
module gfxdiv_ratio_dec #(
  parameter int CODE_W = 7,
  parameter int NQ_W   = 9
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [NQ_W-1:0]   nq_o
);
  import gfxdiv_pkg::*;

  int c;
  int nq;

  always_comb begin
    c = int'(code_i);
    if (c < HALF_FIRST) begin
      // quarter steps
      nq = QTR_BASE + c;
    end else if (c < WHOLE_FIRST) begin
      // half steps
      nq = HALF_BASE + 2 * (c - HALF_FIRST);
    end else begin
      // whole steps
      nq = 4 * (c - WHOLE_SHIFT);
    end
    nq_o = NQ_W'(nq);
  end

endmodule

// File: rtl/gfxdiv_phase_acc.sv
module gfxdiv_phase_acc #(
  parameter int NQ_W     = 9,
  parameter int ACC_STEP = 4,
  parameter int RESET_NQ = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_i,
  input  logic [NQ_W-1:0] nq_req_i,
  output logic            hit_o,
  output logic            strobe_q_o,
  output logic [NQ_W-1:0] nq_act_o,
  output logic [NQ_W-1:0] acc_o
);

  localparam int SUM_W = NQ_W + 1;

  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] nxt;

  always_comb begin
    sum   = {1'b0, acc_o} + SUM_W'(ACC_STEP);
    hit_o = tick_i && (sum >= {1'b0, nq_act_o});
    nxt   = hit_o ? (sum - {1'b0, nq_act_o}) : sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o      <= '0;
      nq_act_o   <= NQ_W'(RESET_NQ);
      strobe_q_o <= 1'b0;
    end else begin
      strobe_q_o <= hit_o;
      if (tick_i) begin
        acc_o <= nxt[NQ_W-1:0];
      end
      if (hit_o) begin
        // the requested code is captured only at a strobe
        nq_act_o <= nq_req_i;
      end
    end
  end

endmodule

// File: rtl/gfxdiv_clk_toggle.sv
module gfxdiv_clk_toggle (
  input  logic clk,
  input  logic rst,
  input  logic hit_i,
  output logic clk_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_o <= 1'b0;
    end else if (hit_i) begin
      clk_o <= ~clk_o;
    end
  end

endmodule

// File: rtl/gfx_frac_clkdiv.sv
module gfx_frac_clkdiv #(
  parameter int CODE_W   = 7,
  parameter int NQ_W     = 9,
  parameter int ACC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_sel,
  input  logic              tick_a,
  input  logic              tick_b,
  input  logic [CODE_W-1:0] ratio_code,
  output logic              strobe_o,
  output logic              clk_o
);

  logic            tick_sel;
  logic [NQ_W-1:0] nq_req;
  logic [NQ_W-1:0] nq_act;
  logic [NQ_W-1:0] acc_q;
  logic            hit;

  assign tick_sel = src_sel ? tick_b : tick_a;

  gfxdiv_ratio_dec #(
    .CODE_W(CODE_W),
    .NQ_W  (NQ_W)
  ) u_dec (
    .code_i(ratio_code),
    .nq_o  (nq_req)
  );

  gfxdiv_phase_acc #(
    .NQ_W    (NQ_W),
    .ACC_STEP(ACC_STEP),
    .RESET_NQ(ACC_STEP)
  ) u_acc (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_sel),
    .nq_req_i  (nq_req),
    .hit_o     (hit),
    .strobe_q_o(strobe_o),
    .nq_act_o  (nq_act),
    .acc_o     (acc_q)
  );

  gfxdiv_clk_toggle u_tog (
    .clk  (clk),
    .rst  (rst),
    .hit_i(hit),
    .clk_o(clk_o)
  );

endmodule

// File: rtl/gfxdiv_chk.sv
module gfxdiv_chk #(
  parameter int NQ_W = 9
) (
  input logic            clk,
  input logic            rst,
  input logic            src_sel,
  input logic            tick_a,
  input logic            tick_b,
  input logic            strobe_o,
  input logic            clk_o,
  input logic [NQ_W-1:0] nq_act,
  input logic [NQ_W-1:0] acc_q
);

  a_r7_toggle_on_strobe: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> (clk_o != $past(clk_o)));

  a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
    !strobe_o |-> $stable(clk_o));

  a_r6_ratio_held: assert property (@(posedge clk) disable iff (rst)
    !strobe_o |-> $stable(nq_act));

  a_r4_phase_below_ratio: assert property (@(posedge clk) disable iff (rst)
    acc_q < nq_act);

  a_r9_no_tick_a: assert property (@(posedge clk) disable iff (rst)
    (!$past(src_sel) && !$past(tick_a)) |-> !strobe_o);

  a_r9_no_tick_b: assert property (@(posedge clk) disable iff (rst)
    ($past(src_sel) && !$past(tick_b)) |-> !strobe_o);

  a_r8_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!strobe_o && !clk_o));

endmodule

bind gfx_frac_clkdiv gfxdiv_chk #(.NQ_W(NQ_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .src_sel (src_sel),
  .tick_a  (tick_a),
  .tick_b  (tick_b),
  .strobe_o(strobe_o),
  .clk_o   (clk_o),
  .nq_act  (nq_act),
  .acc_q   (acc_q)
);

// File: tb/tb_gfx_frac_clkdiv.sv
module tb_gfx_frac_clkdiv;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       src_sel = 1'b0;
  logic       tick_a = 1'b1;
  logic       tick_b = 1'b0;
  logic [6:0] code = '0;
  logic       strobe;
  logic       clk_out;

  always #10 clk = ~clk;  // 50 MHz

  gfx_frac_clkdiv dut (
    .clk       (clk),
    .rst       (rst),
    .src_sel   (src_sel),
    .tick_a    (tick_a),
    .tick_b    (tick_b),
    .ratio_code(code),
    .strobe_o  (strobe),
    .clk_o     (clk_out)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit alt_b = 1'b0;

  typedef struct {
    int    code;
    int    nq;
    string tag;
  } item_t;

  item_t sb[$];

  function automatic int exp_nq(int c);
    if (c < 64)      return 4 + c;                 // R1
    else if (c < 95) return 68 + 2 * (c - 64);     // R2
    else             return 4 * (c - 63);          // R3
  endfunction

  function automatic string region_tag(int c);
    if (c < 64)      return "R1";
    else if (c < 95) return "R2";
    else             return "R3";
  endfunction

  task automatic cyc();
    @(negedge clk);
    if (alt_b) tick_b = ~tick_b;
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_strobe(string req, output int gap);
    gap = 0;
    do begin
      cyc();
      gap++;
    end while (!strobe && gap < 1000);
    if (!strobe) chk(1'b0, req, "no strobe seen", gap, 0);
  endtask

  // Driver: push the expected item, apply the code, wait for the capture strobe
  task automatic drive_code(int c);
    item_t it;
    int    g;
    it.code = c;
    it.nq   = exp_nq(c);
    it.tag  = region_tag(c);
    sb.push_back(it);
    code = 7'(c);
    wait_strobe("R6", g);
  endtask

  // Monitor: pop the expected item and compare over a window of N ticks
  task automatic observe();
    item_t it;
    int    cnt, tog, last, lo, hi, bad_gap;
    logic  prev;
    it      = sb.pop_front();
    cnt     = 0;
    tog     = 0;
    last    = 0;
    bad_gap = 0;
    lo      = it.nq / 4;
    hi      = (it.nq + 3) / 4;
    prev    = clk_out;
    for (int i = 1; i <= it.nq; i++) begin
      cyc();
      if (strobe) begin
        cnt++;
        if ((i - last) < lo || (i - last) > hi) bad_gap = i - last;
        last = i;
      end
      if (clk_out != prev) tog++;
      prev = clk_out;
    end
    chk(cnt == 4, it.tag, $sformatf("R4 strobes over N ticks, code %0d", it.code), cnt, 4);
    chk(bad_gap == 0, "R5", $sformatf("strobe gap outside floor/ceil, code %0d", it.code),
        bad_gap, lo);
    chk(tog == cnt, "R7", $sformatf("clk_o toggles vs strobes, code %0d", it.code), tog, cnt);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int g;
    logic prev;

    // R8: outputs quiet while reset is held
    for (int i = 0; i < 4; i++) begin
      cyc();
      chk(strobe == 1'b0, "R8", "strobe in reset", int'(strobe), 0);
      chk(clk_out == 1'b0, "R8", "clk_o in reset", int'(clk_out), 0);
    end
    rst = 1'b0;

    // R8: ratio 1 after reset, a strobe every cycle
    for (int i = 0; i < 6; i++) begin
      cyc();
      chk(strobe == 1'b1, "R8", "ratio-1 strobe after reset", int'(strobe), 1);
    end

    // Every code: R1, R2, R3, R4, R5, R7
    for (int c = 0; c < 128; c++) begin
      drive_code(c);
      observe();
    end

    // R6: slow-to-fast change applies only after the pending strobe
    drive_code(127);
    void'(sb.pop_front());
    wait_strobe("R6", g);
    code = 7'd0;
    wait_strobe("R6", g);
    chk(g == 64, "R6", "old ratio kept until next strobe", g, 64);
    cyc();
    chk(strobe == 1'b1, "R6", "new ratio in force", int'(strobe), 1);

    // R9: source B selected, tick every other cycle, tick_a idle
    tick_a  = 1'b0;
    src_sel = 1'b1;
    alt_b   = 1'b1;
    drive_code(4);
    void'(sb.pop_front());
    g = 0;
    for (int i = 0; i < 16; i++) begin
      cyc();
      if (strobe) g++;
    end
    chk(g == 4, "R9", "strobes on tick_b over 16 cycles", g, 4);

    // R9: unselected tick_a active, tick_b silent: nothing moves
    alt_b  = 1'b0;
    tick_b = 1'b0;
    tick_a = 1'b1;
    cyc();
    prev = clk_out;
    g = 0;
    for (int i = 0; i < 20; i++) begin
      cyc();
      if (strobe || clk_out != prev) g++;
    end
    chk(g == 0, "R9", "activity with unselected tick only", g, 0);

    // R9: switching back to source A resumes strobes
    src_sel = 1'b0;
    wait_strobe("R9", g);
    chk(g <= 3, "R9", "strobe after selecting tick_a", g, 2);

    summary();
    $finish;
  end

endmodule